// File: doc/BRIEF.md
# Converter Serial Frame Port

This block is the digital serial port of a multichannel successive-approximation converter. It runs entirely in the system clock domain. It samples an active-low chip select, a serial clock and a data-in line once per system clock, and finds their edges internally. A frame opens on a falling edge of chip select. That edge also freezes the newest sample from the parallel sample port, which acts as the hold point for the result. Over sixteen serial clock periods the port shifts out a tagged, signed result and, at the same time, shifts in a 16-bit command word.

A command whose write flag is set is steered to one of four configuration registers. The control register is committed one serial edge early, on the 15th rising edge. The other three registers are committed on the 16th rising edge.

After each transfer, a programmable quiet interval must pass before the next frame may start. A frame that starts too soon raises a sticky error and returns an all-zero word.

Top module: `adcsp_serial_port`

## Requirements
- R1: After reset, `dout_oe` and `dout` are low, all four configuration registers read zero and `quiet_err` is low.
- R2: A falling edge of `cs_n` starts a frame and freezes the result word: the newest sample accepted with `smp_valid` before that edge. Samples arriving later in the frame do not alter the word being shifted out.
- R3: The result word goes out MSB first, with bits 15:13 holding the channel tag and bits 12:0 holding the 13-bit two's-complement result (bit 12 is the sign). Bit 15 is on `dout` right after the frame starts. The next bit appears after each falling `sclk` edge that follows rising edges 1 to 15.
- R4: `din` is sampled on rising `sclk` edges, MSB first. Command bit 15 is the write flag, bits 14:13 select the target register (00 control, 01 sequence, 10 range A, 11 range B), and bits 12:0 are the payload.
- R5: A control write commits on the 15th rising edge and stores command bits 12:1 in the 12-bit `ctrl_reg`. The 16th bit is ignored, and the commit stands even if the frame is then aborted.
- R6: Writes to sequence, range A or range B commit the full 13-bit payload on the 16th rising edge.
- R7: A command whose write flag is 0 changes no register.
- R8: If `cs_n` rises before the 16th rising edge, the frame is aborted and no 16th-edge register is written. A control write is also lost if the abort comes before the 15th edge.
- R9: Each transfer end (the 16th rising edge, or an abort) loads a counter with `quiet_cycles`, and the counter then counts down once per clock. A frame start while the counter is nonzero sets the sticky `quiet_err` and shifts out all zeros, while the command is still decoded.
- R10: `dout_oe` equals the inverse of `cs_n` delayed by one clock. `dout` is low whenever `dout_oe` is low, and also once the 16th rising edge has passed.
- R11: Chip select may idle low after a complete frame. Serial clock edges in that idle state do nothing, and a new frame needs a rise and then a fall of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial command data |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| smp_valid | input | 1 | Sample port strobe |
| smp_chan | input | 3 | Channel tag of the sample |
| smp_res | input | 13 | Signed conversion result |
| quiet_cycles | input | 8 | Quiet interval in clock cycles |
| ctrl_reg | output | 12 | Control register |
| seq_reg | output | 13 | Sequence register |
| rng1_reg | output | 13 | Range A register |
| rng2_reg | output | 13 | Range B register |
| quiet_err | output | 1 | Sticky early-start error |

## Verification
Full frames aimed at each of the four addresses, with payloads of different bit densities, separate the address decode and the early control commit from the end-of-frame commit. Frames cut after 10 and after 15 serial clocks show which commits survive an abort. A sample strobe in the middle of a frame, and a negative result, show where the hold point lies and that the sign is in the right position. A frame started straight after another, compared with one started after a wait, checks the quiet-interval boundary. A frame that holds chip select low while the serial clock keeps toggling covers the idle-low case.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

    localparam int CHAN_W    = 3;
    localparam int RES_W     = 13;
    localparam int ADDR_W    = 2;
    localparam int PAY_W     = 13;
    localparam int FRAME_LEN = 1 + ADDR_W + PAY_W;
    localparam int CTRL_W    = PAY_W - 1;
    localparam int CTRL_EDGE = FRAME_LEN - 1;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int NUM_REGS  = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_SEQ  = 2'd1,
        SEL_RNGA = 2'd2,
        SEL_RNGB = 2'd3
    } reg_sel_e;

    // Full command word as seen after the last rising edge
    typedef struct packed {
        logic               wr;
        reg_sel_e           sel;
        logic [PAY_W-1:0]   pay;
    } cmd_t;

    // Truncated command word seen one edge early, for the control commit
    typedef struct packed {
        logic               wr;
        reg_sel_e           sel;
        logic [CTRL_W-1:0]  pay;
    } early_cmd_t;

    typedef struct packed {
        logic [CHAN_W-1:0]  chan;
        logic [RES_W-1:0]   res;
    } result_t;

    typedef struct packed {
        logic cs_fall;
        logic sck_rise;
        logic sck_fall;
    } edges_t;

    function automatic cmd_t to_cmd(input logic [FRAME_LEN-1:0] w);
        return cmd_t'(w);
    endfunction

    function automatic early_cmd_t to_early(input logic [FRAME_LEN-2:0] w);
        return early_cmd_t'(w);
    endfunction

endpackage

// File: rtl/adcsp_edge_det.sv
module adcsp_edge_det
    import adcsp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sclk,
    output edges_t edg
);
    logic cs_d;
    logic sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b1;
        end else begin
            cs_d  <= cs_n;
            sck_d <= sclk;
        end
    end

    always_comb begin
        edg.cs_fall  = cs_d & ~cs_n;
        edg.sck_rise = ~sck_d & sclk;
        edg.sck_fall = sck_d & ~sclk;
    end
endmodule

// File: rtl/adcsp_frame_ctrl.sv
module adcsp_frame_ctrl
    import adcsp_pkg::*;
#(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  edges_t        edg,
    input  logic          cs_n,
    input  logic [QW-1:0] quiet_cycles,
    output logic          load_frame,
    output logic          blank,
    output logic          take_rise,
    output logic          shift_out,
    output logic          ctrl_we,
    output logic          full_we,
    output logic          end_evt,
    output logic          quiet_err
);
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [QW-1:0]    qcnt;
    logic             abort;
    logic             done;

    always_comb begin
        take_rise  = active & ~cs_n & edg.sck_rise;
        abort      = active & cs_n;
        done       = take_rise & (cnt == CNT_W'(FRAME_LEN - 1));
        end_evt    = abort | done;
        shift_out  = active & ~cs_n & edg.sck_fall & (cnt != '0);
        ctrl_we    = take_rise & (cnt == CNT_W'(CTRL_EDGE - 1));
        full_we    = done;
        load_frame = edg.cs_fall;
        blank      = (qcnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            quiet_err <= 1'b0;
        end else if (load_frame) begin
            active <= 1'b1;
            cnt    <= '0;
            if (blank) quiet_err <= 1'b1;
        end else if (end_evt) begin
            active <= 1'b0;
        end else if (take_rise) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          qcnt <= '0;
        else if (end_evt) qcnt <= quiet_cycles;
        else if (blank)   qcnt <= qcnt - 1'b1;
    end
endmodule

// File: rtl/adcsp_shift_io.sv
module adcsp_shift_io
    import adcsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 din,
    input  result_t              word,
    input  logic                 load_frame,
    input  logic                 blank,
    input  logic                 take_rise,
    input  logic                 shift_out,
    input  logic                 end_evt,
    output logic [FRAME_LEN-1:0] in_next,
    output logic                 dout,
    output logic                 dout_oe
);
    logic [FRAME_LEN-1:0] out_sr;
    logic [FRAME_LEN-2:0] in_sr;

    assign in_next = {in_sr, din};
    assign dout    = out_sr[FRAME_LEN-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sr  <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout_oe <= ~cs_n;
            if (load_frame)     out_sr <= blank ? '0 : word;
            else if (end_evt)   out_sr <= '0;
            else if (shift_out) out_sr <= {out_sr[FRAME_LEN-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             in_sr <= '0;
        else if (load_frame) in_sr <= '0;
        else if (take_rise)  in_sr <= in_next[FRAME_LEN-2:0];
    end
endmodule

// File: rtl/adcsp_reg_bank.sv
module adcsp_reg_bank
    import adcsp_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               ctrl_we,
    input  logic                               full_we,
    input  logic [FRAME_LEN-1:0]               in_next,
    output logic [CTRL_W-1:0]                  ctrl_q,
    output logic [NUM_REGS-2:0][PAY_W-1:0]     wide_q
);
    early_cmd_t ecmd;
    cmd_t       fcmd;

    assign ecmd = to_early(in_next[FRAME_LEN-2:0]);
    assign fcmd = to_cmd(in_next);

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (ctrl_we && ecmd.wr && ecmd.sel == SEL_CTRL) ctrl_q <= ecmd.pay;
    end

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_wide
        logic [PAY_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst) r_q <= '0;
            else if (full_we && fcmd.wr && fcmd.sel == reg_sel_e'(g)) r_q <= fcmd.pay;
        end
        assign wide_q[g-1] = r_q;
    end
endmodule

// File: rtl/adcsp_serial_port.sv
module adcsp_serial_port
    import adcsp_pkg::*;
#(
    parameter int QW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [RES_W-1:0]  smp_res,
    input  logic [QW-1:0]     quiet_cycles,
    output logic [CTRL_W-1:0] ctrl_reg,
    output logic [PAY_W-1:0]  seq_reg,
    output logic [PAY_W-1:0]  rng1_reg,
    output logic [PAY_W-1:0]  rng2_reg,
    output logic              quiet_err
);
    edges_t                        edg;
    result_t                       held;
    logic                          load_frame, blank, take_rise, shift_out;
    logic                          ctrl_we, full_we, end_evt;
    logic [FRAME_LEN-1:0]          in_next;
    logic [NUM_REGS-2:0][PAY_W-1:0] wide_q;

    // Newest sample; frozen into the shifter on the frame start edge
    always_ff @(posedge clk) begin
        if (rst)            held <= '0;
        else if (smp_valid) held <= '{chan: smp_chan, res: smp_res};
    end

    adcsp_edge_det u_edge (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .edg (edg)
    );

    adcsp_frame_ctrl #(.QW(QW)) u_ctrl (
        .clk (clk), .rst (rst), .edg (edg), .cs_n (cs_n),
        .quiet_cycles (quiet_cycles),
        .load_frame (load_frame), .blank (blank), .take_rise (take_rise),
        .shift_out (shift_out), .ctrl_we (ctrl_we), .full_we (full_we),
        .end_evt (end_evt), .quiet_err (quiet_err)
    );

    adcsp_shift_io u_io (
        .clk (clk), .rst (rst), .cs_n (cs_n), .din (din), .word (held),
        .load_frame (load_frame), .blank (blank), .take_rise (take_rise),
        .shift_out (shift_out), .end_evt (end_evt), .in_next (in_next),
        .dout (dout), .dout_oe (dout_oe)
    );

    adcsp_reg_bank u_regs (
        .clk (clk), .rst (rst), .ctrl_we (ctrl_we), .full_we (full_we),
        .in_next (in_next), .ctrl_q (ctrl_reg), .wide_q (wide_q)
    );

    assign seq_reg  = wide_q[0];
    assign rng1_reg = wide_q[1];
    assign rng2_reg = wide_q[2];
endmodule

// File: rtl/adcsp_serial_port_chk.sv
module adcsp_serial_port_chk
    import adcsp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sclk,
    input logic              dout,
    input logic              dout_oe,
    input logic [CTRL_W-1:0] ctrl_reg,
    input logic [PAY_W-1:0]  seq_reg,
    input logic [PAY_W-1:0]  rng1_reg,
    input logic [PAY_W-1:0]  rng2_reg,
    input logic              quiet_err
);
    assert_dout_oe_tracks_cs_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> dout_oe == !$past(cs_n));

    assert_dout_low_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> !dout);

    assert_ctrl_commit_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_reg) |-> (!$past(cs_n) && $past(sclk)));

    assert_regs_hold_cs_high_R8: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(seq_reg) && $stable(rng1_reg) && $stable(rng2_reg)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        quiet_err |=> quiet_err);

    assert_blank_on_err_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(quiet_err) |-> !dout);
endmodule

bind adcsp_serial_port adcsp_serial_port_chk chk_i (
    .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .dout (dout),
    .dout_oe (dout_oe), .ctrl_reg (ctrl_reg), .seq_reg (seq_reg),
    .rng1_reg (rng1_reg), .rng2_reg (rng2_reg), .quiet_err (quiet_err)
);

// File: tb/adcsp_serial_port_tb_top.sv
module adcsp_serial_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_chan = '0;
    logic [12:0] smp_res = '0;
    logic [7:0]  quiet_cycles = '0;
    logic        dout, dout_oe, quiet_err;
    logic [11:0] ctrl_reg;
    logic [12:0] seq_reg, rng1_reg, rng2_reg;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    adcsp_serial_port dut_i (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .din (din),
        .dout (dout), .dout_oe (dout_oe), .smp_valid (smp_valid),
        .smp_chan (smp_chan), .smp_res (smp_res), .quiet_cycles (quiet_cycles),
        .ctrl_reg (ctrl_reg), .seq_reg (seq_reg), .rng1_reg (rng1_reg),
        .rng2_reg (rng2_reg), .quiet_err (quiet_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit  out_q[$];
    int  m_rises, m_cmd, m_quiet, m_word;
    bit  m_in_frame, m_cs_p, m_sck_p, m_oe, m_err;
    int  m_ctrl, m_seq, m_rng1, m_rng2;
    bit  m_end;

    always @(posedge clk) begin
        if (rst) begin
            out_q.delete();
            m_rises = 0; m_cmd = 0; m_quiet = 0; m_word = 0;
            m_in_frame = 0; m_cs_p = 1; m_sck_p = 1; m_oe = 0; m_err = 0;
            m_ctrl = 0; m_seq = 0; m_rng1 = 0; m_rng2 = 0;
        end else begin
            m_end = 0;
            m_oe = !cs_n;
            if (m_cs_p && !cs_n) begin
                m_in_frame = 1; m_rises = 0; m_cmd = 0;
                out_q.delete();
                if (m_quiet > 0) m_err = 1;
                for (int i = 15; i >= 0; i--)
                    out_q.push_back(m_quiet > 0 ? 1'b0 : m_word[i]);
            end else if (m_in_frame) begin
                if (cs_n) begin
                    m_in_frame = 0; out_q.delete(); m_end = 1;
                end else if (!m_sck_p && sclk) begin
                    m_cmd = m_cmd * 2 + int'(din);
                    m_rises++;
                    if (m_rises == 15 && ((m_cmd >> 14) & 1) == 1 && ((m_cmd >> 12) & 3) == 0)
                        m_ctrl = m_cmd & 'hFFF;
                    if (m_rises == 16) begin
                        if (((m_cmd >> 15) & 1) == 1) begin
                            case ((m_cmd >> 13) & 3)
                                1: m_seq  = m_cmd & 'h1FFF;
                                2: m_rng1 = m_cmd & 'h1FFF;
                                3: m_rng2 = m_cmd & 'h1FFF;
                                default: ;
                            endcase
                        end
                        m_in_frame = 0; out_q.delete(); m_end = 1;
                    end
                end else if (m_sck_p && !sclk && m_rises >= 1 && m_rises <= 15) begin
                    void'(out_q.pop_front());
                end
            end
            if (m_end) m_quiet = int'(quiet_cycles);
            else if (m_quiet > 0) m_quiet--;
            if (smp_valid) m_word = int'({smp_chan, smp_res});
            m_cs_p = cs_n; m_sck_p = sclk;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 dout vs model", int'(dout), (out_q.size() != 0) ? int'(out_q[0]) : 0);
            chk("R10 dout_oe vs model", int'(dout_oe), int'(m_oe));
            chk("R9 quiet_err vs model", int'(quiet_err), int'(m_err));
            chk("R5 ctrl_reg vs model", int'(ctrl_reg), m_ctrl);
            chk("R6 seq_reg vs model", int'(seq_reg), m_seq);
            chk("R6 rng1_reg vs model", int'(rng1_reg), m_rng1);
            chk("R6 rng2_reg vs model", int'(rng2_reg), m_rng2);
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_frame(input logic [15:0] cmd, input int nclk,
                             input bit idle_low, output logic [15:0] rx);
        rx = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            sclk = 1'b0; din = cmd[15-i];
            repeat (2) @(negedge clk);
            rx[15-i] = dout;
            sclk = 1'b1;
            repeat (2) @(negedge clk);
        end
        if (idle_low) begin
            for (int k = 0; k < 3; k++) begin
                sclk = 1'b0; din = 1'b1;
                repeat (2) @(negedge clk);
                chk("R10 dout low after frame", int'(dout), 0);
                chk("R11 oe held while idle low", int'(dout_oe), 1);
                sclk = 1'b1;
                repeat (2) @(negedge clk);
            end
        end
        cs_n = 1'b1; din = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic put_sample(input logic [2:0] ch, input logic [12:0] r);
        @(negedge clk); smp_valid = 1'b1; smp_chan = ch; smp_res = r;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] rx;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 dout_oe", int'(dout_oe), 0);
        chk("R1 dout", int'(dout), 0);
        chk("R1 ctrl", int'(ctrl_reg), 0);
        chk("R1 seq", int'(seq_reg), 0);
        chk("R1 err", int'(quiet_err), 0);

        // R3, R4, R6: negative result, write sequence register
        put_sample(3'd5, 13'h1FFD);
        run_frame({1'b1, 2'b01, 13'h0ABC}, 16, 0, rx);
        chk("R3 result word ch5 negative", int'(rx), 'hBFFD);
        chk("R6 seq written", int'(seq_reg), 'h0ABC);
        chk("R10 oe low after cs high", int'(dout_oe), 0);

        // R2: sample arriving mid-frame does not disturb the held word
        fork
            run_frame({1'b1, 2'b10, 13'h1555}, 16, 0, rx);
            begin repeat (12) @(negedge clk); smp_valid = 1'b1; smp_chan = 3'd2;
                  smp_res = 13'h0123; @(negedge clk); smp_valid = 1'b0; end
        join
        chk("R2 held word", int'(rx), 'hBFFD);
        chk("R6 range A written", int'(rng1_reg), 'h1555);
        run_frame({1'b1, 2'b11, 13'h0F0F}, 16, 0, rx);
        chk("R2 new sample next frame", int'(rx), 'h4123);
        chk("R6 range B written", int'(rng2_reg), 'h0F0F);

        // R5: control takes bits 12:1
        run_frame({1'b1, 2'b00, 13'h1234}, 16, 0, rx);
        chk("R5 ctrl written", int'(ctrl_reg), 'h91A);

        // R7: write flag clear
        run_frame({1'b0, 2'b01, 13'h1FFF}, 16, 0, rx);
        chk("R7 seq untouched", int'(seq_reg), 'h0ABC);
        run_frame({1'b0, 2'b00, 13'h1FFF}, 16, 0, rx);
        chk("R7 ctrl untouched", int'(ctrl_reg), 'h91A);

        // R8 aborts
        run_frame({1'b1, 2'b10, 13'h0001}, 10, 0, rx);
        chk("R8 range A kept after abort", int'(rng1_reg), 'h1555);
        run_frame({1'b1, 2'b00, 13'h0002}, 10, 0, rx);
        chk("R8 ctrl kept after early abort", int'(ctrl_reg), 'h91A);
        run_frame({1'b1, 2'b11, 13'h1111}, 15, 0, rx);
        chk("R8 range B kept after 15 clocks", int'(rng2_reg), 'h0F0F);
        run_frame({1'b1, 2'b00, 13'h0777}, 15, 0, rx);
        chk("R5 ctrl commits at 15th edge", int'(ctrl_reg), 'h3BB);

        // R11: idle low after a full frame
        run_frame({1'b1, 2'b01, 13'h0042}, 16, 1, rx);
        chk("R11 seq written once", int'(seq_reg), 'h0042);

        // R9: quiet interval
        quiet_cycles = 8'd6;
        run_frame({1'b0, 2'b00, 13'h0}, 16, 0, rx);
        repeat (10) @(negedge clk);
        run_frame({1'b0, 2'b00, 13'h0}, 16, 0, rx);
        chk("R9 no error after wait", int'(quiet_err), 0);
        chk("R9 word after wait", int'(rx), 'h4123);
        quiet_cycles = 8'd20;
        run_frame({1'b0, 2'b00, 13'h0}, 16, 0, rx);
        run_frame({1'b1, 2'b10, 13'h0AAA}, 16, 0, rx);
        chk("R9 error raised", int'(quiet_err), 1);
        chk("R9 zero word", int'(rx), 0);
        chk("R9 command still decoded", int'(rng1_reg), 'h0AAA);
        repeat (30) @(negedge clk);
        run_frame({1'b0, 2'b00, 13'h0}, 16, 0, rx);
        chk("R9 error sticky", int'(quiet_err), 1);
        chk("R9 word back after wait", int'(rx), 'h4123);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule